// File: doc/BRIEF.md
# GPIO Port Register File

This block is the register-level control of one 16-pin general-purpose I/O port. It sits on a simple 32-bit register bus. The bus carries a byte address, a write strobe with byte enables, and a read strobe whose data comes back registered. The block stores the per-pin configuration: direction mode, output type, speed, pull and alternate-function source. It also holds the output data latch and presents a synchronized copy of the pin levels.

Software can change single output bits without a read-modify-write sequence. A combined write-only register sets and clears bits in one write, and set wins when both are requested for the same pin. A second write-only alias only clears bits. From the stored state the block computes, for each pin, the pad drive value, output enable, open-drain flag, pull-up and pull-down controls, and an analog flag. In alternate-function mode the peripheral's value and enable take over the pad. The stored speed code and the function-select nibbles go out unchanged.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is asserted, and until the second clock edge after it is released, all stored registers are 0. After that, every register reads 0, and pad_oe, pad_speed and af_sel are 0.
- R2: The word registers are at byte offsets 0x00 mode, 0x04 output type, 0x08 speed, 0x0C pull, 0x10 input, 0x14 output data, 0x18 set/clear, 0x1C clear-only, 0x20 function select for pins 0-7 and 0x24 function select for pins 8-15. Mode, speed and pull use bits [2n+1:2n] for pin n, and function select uses 4 bits per pin at [4(n mod 8)+3:4(n mod 8)]. The output-type register is 16 bits wide, and its bits [31:16] read 0.
- R3: In a write, only the bytes whose byte-enable bit is 1 are changed: bus_be[k] covers bits [8k+7:8k].
- R4: A write to the output data register replaces all 16 output bits at once, subject to the byte enables. The new value appears on pad_out after the write's clock edge.
- R5: A write to the set/clear register drives output bit n to 1 where wdata[n] is 1, and to 0 where wdata[n+16] is 1. Bits written 0 leave their outputs unchanged. Reads of this register return 0.
- R6: When a set/clear write has both wdata[n] and wdata[n+16] high, output bit n becomes 1.
- R7: A write to the clear-only register clears output bit n where wdata[n] is 1. Bits [31:16] of that write have no effect, and reads of the register return 0.
- R8: The input register shows pin_in through two synchronizing flops. A read captured at clock edge k returns the pin level driven before edge k-2. Writes to the input register are ignored.
- R9: In general output mode (01), pad_out is the output bit. With push-pull type (0) pad_oe is 1. With open-drain type (1) pad_oe is 1 only when the output bit is 0. pad_od mirrors the type bit.
- R10: In alternate-function mode (10), pad_out and pad_oe follow af_out and af_oe for that pin, whatever the output data and type registers hold. af_sel carries {select 8-15, select 0-7}.
- R11: In input mode (00) and analog mode (11), pad_oe is 0, and pad_analog is 1 only in analog mode. Pull code 01 raises pad_pu, code 10 raises pad_pd, and 00 or 11 raises neither. pad_speed forwards the speed register as stored.
- R12: Writes to unmapped offsets (0x28 and above), and writes with bus_addr[1:0] not 00, change no register. Reads of such addresses return 0.
- R13: Read data appears on bus_rdata after the clock edge that samples bus_rd and is held for one cycle. In a cycle that follows no read, bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for writes |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 16 | Pad input levels (asynchronous) |
| af_out | input | 16 | Peripheral output values for alternate-function pins |
| af_oe | input | 16 | Peripheral output enables for alternate-function pins |
| pad_out | output | 16 | Pad drive value |
| pad_oe | output | 16 | Pad output enable |
| pad_od | output | 16 | Open-drain type per pin |
| pad_pu | output | 16 | Pull-up enable |
| pad_pd | output | 16 | Pull-down enable |
| pad_analog | output | 16 | Pin is in analog mode |
| pad_speed | output | 32 | Speed code, two bits per pin |
| af_sel | output | 64 | Function source select, four bits per pin |

## Verification
A register write takes effect at the clock edge that samples bus_wr. The pad outputs are decoded from registers without further flops, so the bench samples them at the falling edge after the write. Read data is registered, so each read drives bus_rd for one cycle and samples bus_rdata at the following falling edge, one edge after capture. The input path is the deepest. The bench changes pin_in together with three back-to-back reads and expects the old value from the first two and the new value only from the third.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned PINS   = 16;
  localparam int unsigned FLD_W  = 2;
  localparam int unsigned SEL_W  = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = DATA_W / 8;

  typedef enum logic [3:0] {
    OFS_MODE  = 4'd0,
    OFS_TYPE  = 4'd1,
    OFS_SPEED = 4'd2,
    OFS_PULL  = 4'd3,
    OFS_IN    = 4'd4,
    OFS_OUT   = 4'd5,
    OFS_SETCL = 4'd6,
    OFS_CLR   = 4'd7,
    OFS_SELLO = 4'd8,
    OFS_SELHI = 4'd9
  } reg_ofs_e;

  localparam logic [1:0] MODE_IN  = 2'b00;
  localparam logic [1:0] MODE_OUT = 2'b01;
  localparam logic [1:0] MODE_ALT = 2'b10;
  localparam logic [1:0] MODE_ANA = 2'b11;

  function automatic logic [DATA_W-1:0] be_to_mask(input logic [BE_W-1:0] be);
    logic [DATA_W-1:0] m;
    for (int k = 0; k < int'(BE_W); k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v,
                                              input logic [DATA_W-1:0] new_v,
                                              input logic [DATA_W-1:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < int'(STAGES); s++) begin : g_stage
      logic [WIDTH-1:0] stg_d;
      if (s == 0) begin : g_first
        assign stg_d = d;
      end else begin : g_next
        assign stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_out_data.sv
module gpio_out_data #(
  parameter int unsigned WIDTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_full,
  input  logic               wr_setclr,
  input  logic               wr_clr,
  input  logic [2*WIDTH-1:0] wdata,
  input  logic [2*WIDTH-1:0] wmask,
  output logic [WIDTH-1:0]   odr
);
  logic [WIDTH-1:0] odr_q, odr_d;
  logic [WIDTH-1:0] set_v, clr_hi_v, clr_lo_v;
  logic             odr_en;

  assign set_v    = wdata[WIDTH-1:0] & wmask[WIDTH-1:0];
  assign clr_lo_v = set_v;
  assign clr_hi_v = wdata[2*WIDTH-1:WIDTH] & wmask[2*WIDTH-1:WIDTH];
  assign odr_en   = wr_full | wr_setclr | wr_clr;

  always_comb begin
    odr_d = odr_q;
    if (wr_full)        odr_d = (odr_q & ~wmask[WIDTH-1:0]) | set_v;
    else if (wr_setclr) odr_d = (odr_q & ~clr_hi_v) | set_v;
    else if (wr_clr)    odr_d = odr_q & ~clr_lo_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      odr_q <= '0;
    else if (odr_en) odr_q <= odr_d;
  end

  assign odr = odr_q;

  // R5: requested clears land unless the same pin is also set
  p_clear_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_setclr |=> ((odr_q & $past(clr_hi_v & ~set_v)) == '0));
  // R5: untouched pins keep their value
  p_keep_other_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_setclr |=> (((odr_q ^ $past(odr_q)) & ~$past(set_v | clr_hi_v)) == '0));
  // R6: set beats clear on the same pin
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_setclr |=> ((odr_q & $past(set_v & clr_hi_v)) == $past(set_v & clr_hi_v)));
  // R7: clear-only alias clears its mask
  p_clear_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((odr_q & $past(clr_lo_v)) == '0));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPIN = 16
) (
  input  logic [2*NPIN-1:0] mode,
  input  logic [NPIN-1:0]   otype,
  input  logic [2*NPIN-1:0] pull,
  input  logic [NPIN-1:0]   odr,
  input  logic [NPIN-1:0]   af_out,
  input  logic [NPIN-1:0]   af_oe,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_od,
  output logic [NPIN-1:0]   pad_pu,
  output logic [NPIN-1:0]   pad_pd,
  output logic [NPIN-1:0]   pad_analog
);
  generate
    for (genvar n = 0; n < int'(NPIN); n++) begin : g_pin
      logic [1:0] m, p;
      assign m = mode[2*n +: 2];
      assign p = pull[2*n +: 2];

      always_comb begin
        pad_out[n] = 1'b0;
        pad_oe[n]  = 1'b0;
        unique case (m)
          MODE_OUT: begin
            pad_out[n] = odr[n];
            pad_oe[n]  = otype[n] ? ~odr[n] : 1'b1;
          end
          MODE_ALT: begin
            pad_out[n] = af_out[n];
            pad_oe[n]  = af_oe[n];
          end
          default: ;
        endcase
      end

      assign pad_od[n]     = otype[n];
      assign pad_pu[n]     = (p == 2'b01);
      assign pad_pd[n]     = (p == 2'b10);
      assign pad_analog[n] = (m == MODE_ANA);
    end
  endgenerate
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [BE_W-1:0]     bus_be,
  input  logic                bus_rd,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [PINS-1:0]     pin_in,
  input  logic [PINS-1:0]     af_out,
  input  logic [PINS-1:0]     af_oe,
  output logic [PINS-1:0]     pad_out,
  output logic [PINS-1:0]     pad_oe,
  output logic [PINS-1:0]     pad_od,
  output logic [PINS-1:0]     pad_pu,
  output logic [PINS-1:0]     pad_pd,
  output logic [PINS-1:0]     pad_analog,
  output logic [FLD_W*PINS-1:0] pad_speed,
  output logic [SEL_W*PINS-1:0] af_sel
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned FW     = FLD_W * PINS;
  localparam int unsigned HALF   = SEL_W * PINS / 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // address decode
  logic [WORD_W-1:0] word;
  logic              aligned;
  logic [DATA_W-1:0] wmask;
  logic hit_mode, hit_type, hit_speed, hit_pull, hit_in, hit_out;
  logic hit_setcl, hit_clr, hit_sello, hit_selhi, hit_any;

  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wmask   = be_to_mask(bus_be);

  assign hit_mode  = aligned && (word == WORD_W'(OFS_MODE));
  assign hit_type  = aligned && (word == WORD_W'(OFS_TYPE));
  assign hit_speed = aligned && (word == WORD_W'(OFS_SPEED));
  assign hit_pull  = aligned && (word == WORD_W'(OFS_PULL));
  assign hit_in    = aligned && (word == WORD_W'(OFS_IN));
  assign hit_out   = aligned && (word == WORD_W'(OFS_OUT));
  assign hit_setcl = aligned && (word == WORD_W'(OFS_SETCL));
  assign hit_clr   = aligned && (word == WORD_W'(OFS_CLR));
  assign hit_sello = aligned && (word == WORD_W'(OFS_SELLO));
  assign hit_selhi = aligned && (word == WORD_W'(OFS_SELHI));
  assign hit_any   = hit_mode | hit_type | hit_speed | hit_pull | hit_in | hit_out
                   | hit_setcl | hit_clr | hit_sello | hit_selhi;

  // configuration registers
  logic [FW-1:0]   mode_q, mode_d, speed_q, speed_d, pull_q, pull_d;
  logic [PINS-1:0] type_q, type_d;
  logic [HALF-1:0] sello_q, sello_d, selhi_q, selhi_d;
  logic            cfg_en;

  assign cfg_en = bus_wr & (hit_mode | hit_type | hit_speed | hit_pull | hit_sello | hit_selhi);

  always_comb begin
    mode_d  = mode_q;
    type_d  = type_q;
    speed_d = speed_q;
    pull_d  = pull_q;
    sello_d = sello_q;
    selhi_d = selhi_q;
    if (hit_mode)  mode_d  = merge(mode_q, bus_wdata, wmask);
    if (hit_type)  type_d  = PINS'(merge(DATA_W'(type_q), bus_wdata, wmask));
    if (hit_speed) speed_d = merge(speed_q, bus_wdata, wmask);
    if (hit_pull)  pull_d  = merge(pull_q, bus_wdata, wmask);
    if (hit_sello) sello_d = merge(sello_q, bus_wdata, wmask);
    if (hit_selhi) selhi_d = merge(selhi_q, bus_wdata, wmask);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_q  <= '0;
      type_q  <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      sello_q <= '0;
      selhi_q <= '0;
    end else if (cfg_en) begin
      mode_q  <= mode_d;
      type_q  <= type_d;
      speed_q <= speed_d;
      pull_q  <= pull_d;
      sello_q <= sello_d;
      selhi_q <= selhi_d;
    end
  end

  // output data and input sampling
  logic [PINS-1:0] odr, idr;

  gpio_out_data #(.WIDTH(PINS)) i_out_data (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_full   (bus_wr & hit_out),
    .wr_setclr (bus_wr & hit_setcl),
    .wr_clr    (bus_wr & hit_clr),
    .wdata     (bus_wdata),
    .wmask     (wmask),
    .odr       (odr)
  );

  gpio_in_sync #(.WIDTH(PINS), .STAGES(2)) i_in_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     (pin_in),
    .q     (idr)
  );

  gpio_pad_ctrl #(.NPIN(PINS)) i_pad_ctrl (
    .mode       (mode_q),
    .otype      (type_q),
    .pull       (pull_q),
    .odr        (odr),
    .af_out     (af_out),
    .af_oe      (af_oe),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .pad_od     (pad_od),
    .pad_pu     (pad_pu),
    .pad_pd     (pad_pd),
    .pad_analog (pad_analog)
  );

  assign pad_speed = speed_q;
  assign af_sel    = {selhi_q, sello_q};

  // read path
  logic [DATA_W-1:0] rd_mux, rdata_q, rdata_d;

  always_comb begin
    rd_mux = '0;
    if (hit_mode)  rd_mux = mode_q;
    if (hit_type)  rd_mux = DATA_W'(type_q);
    if (hit_speed) rd_mux = speed_q;
    if (hit_pull)  rd_mux = pull_q;
    if (hit_in)    rd_mux = DATA_W'(idr);
    if (hit_out)   rd_mux = DATA_W'(odr);
    if (hit_sello) rd_mux = sello_q;
    if (hit_selhi) rd_mux = selhi_q;
  end

  assign rdata_d = bus_rd ? rd_mux : '0;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) rdata_q <= '0;
    else          rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  // R5 / R7: write-only registers read back as zero
  p_wo_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_rd && (hit_setcl || hit_clr)) |=> (bus_rdata == '0));
  // R12: stray writes leave configuration and outputs untouched
  p_stray_write_r12: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && !hit_any) |=> ($stable(mode_q) && $stable(type_q) && $stable(speed_q)
                              && $stable(pull_q) && $stable(odr) && $stable(af_sel)));
  // R13: idle cycle returns zero read data
  p_idle_rdata_r13: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bus_rd |=> (bus_rdata == '0));

  generate
    for (genvar n = 0; n < int'(PINS); n++) begin : g_chk
      // R11: input and analog pins never drive
      p_no_drive_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
        (mode_q[2*n +: 2] == MODE_IN || mode_q[2*n +: 2] == MODE_ANA) |-> !pad_oe[n]);
      // R9: open-drain output releases a high level
      p_od_release_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
        (mode_q[2*n +: 2] == MODE_OUT && type_q[n] && odr[n]) |-> !pad_oe[n]);
      // R10: alternate function owns the pad
      p_alt_owns_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
        (mode_q[2*n +: 2] == MODE_ALT) |-> (pad_oe[n] == af_oe[n] && pad_out[n] == af_out[n]));
    end
  endgenerate
endmodule

// File: tb/test_gpio_port_regs.sv
module test_gpio_port_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_be;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in, af_out, af_oe;
  logic [15:0] pad_out, pad_oe, pad_od, pad_pu, pad_pd, pad_analog;
  logic [31:0] pad_speed;
  logic [63:0] af_sel;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  gpio_port_regs i_gpio_port_regs (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_be, .bus_rd, .bus_rdata,
    .pin_in, .af_out, .af_oe, .pad_out, .pad_oe, .pad_od, .pad_pu, .pad_pd,
    .pad_analog, .pad_speed, .af_sel
  );

  localparam logic [5:0] A_MODE = 6'h00, A_TYPE = 6'h04, A_SPEED = 6'h08, A_PULL = 6'h0C,
                         A_IN = 6'h10, A_OUT = 6'h14, A_SETCL = 6'h18, A_CLR = 6'h1C,
                         A_SELLO = 6'h20, A_SELHI = 6'h24;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 pad_oe", 64'(pad_oe), 64'h0);
    chk("R1 pad_speed", 64'(pad_speed), 64'h0);
    chk("R1 af_sel", af_sel, 64'h0);
    rd(A_MODE, d); chk("R1 mode", 64'(d), 64'h0);
    rd(A_OUT, d);  chk("R1 odr", 64'(d), 64'h0);
  endtask

  task automatic t_config;
    logic [31:0] d;
    wr(A_MODE, 32'h1234_5678); rd(A_MODE, d); chk("R2 mode", 64'(d), 64'h1234_5678);
    wr(A_TYPE, 32'hFFFF_1234); rd(A_TYPE, d); chk("R2 type upper zero", 64'(d), 64'h1234);
    wr(A_SPEED, 32'hC3C3_0F0F); rd(A_SPEED, d); chk("R2 speed", 64'(d), 64'hC3C3_0F0F);
    chk("R11 pad_speed", 64'(pad_speed), 64'hC3C3_0F0F);
    wr(A_SELLO, 32'h7654_3210); wr(A_SELHI, 32'hFEDC_BA98);
    rd(A_SELHI, d); chk("R2 select hi", 64'(d), 64'hFEDC_BA98);
    chk("R10 af_sel", af_sel, 64'hFEDC_BA98_7654_3210);
    wr(A_TYPE, 32'h0); wr(A_SPEED, 32'h0);
  endtask

  task automatic t_strobes;
    logic [31:0] d;
    wr(A_MODE, 32'h0);
    wr(A_MODE, 32'hFFFF_FFFF, 4'b0010);
    rd(A_MODE, d); chk("R3 byte enable", 64'(d), 64'h0000_FF00);
    wr(A_OUT, 32'h0000_ABCD, 4'b0001);
    rd(A_OUT, d); chk("R3 odr byte", 64'(d), 64'h0000_00CD);
  endtask

  task automatic t_odr;
    logic [31:0] d;
    wr(A_MODE, 32'h5555_5555);
    wr(A_OUT, 32'h0000_F0FE);
    chk("R4 pad_out", 64'(pad_out), 64'hF0FE);
    chk("R9 push-pull oe", 64'(pad_oe), 64'hFFFF);
    rd(A_OUT, d); chk("R4 odr read", 64'(d), 64'hF0FE);
  endtask

  task automatic t_setclr;
    logic [31:0] d;
    wr(A_OUT, 32'h0000_F0FE);
    wr(A_SETCL, 32'h00F0_0001);
    chk("R5 set/clear", 64'(pad_out), 64'hF00F);
    rd(A_SETCL, d); chk("R5 reads zero", 64'(d), 64'h0);
    wr(A_OUT, 32'h0);
    wr(A_SETCL, 32'h0005_0007);
    chk("R6 set wins", 64'(pad_out), 64'h0007);
  endtask

  task automatic t_clr;
    logic [31:0] d;
    wr(A_OUT, 32'h0000_FFFF);
    wr(A_CLR, 32'h0001_00F0);
    chk("R7 clear-only", 64'(pad_out), 64'hFF0F);
    rd(A_CLR, d); chk("R7 reads zero", 64'(d), 64'h0);
  endtask

  task automatic t_input;
    logic [31:0] d0, d1, d2;
    pin_in = 16'h1111;
    repeat (3) @(negedge clk);
    pin_in = 16'hA5A5; bus_addr = A_IN; bus_rd = 1'b1;
    @(negedge clk); d0 = bus_rdata;
    @(negedge clk); d1 = bus_rdata;
    @(negedge clk); d2 = bus_rdata;
    bus_rd = 1'b0;
    chk("R8 lag edge1", 64'(d0), 64'h1111);
    chk("R8 lag edge2", 64'(d1), 64'h1111);
    chk("R8 new at edge3", 64'(d2), 64'hA5A5);
    wr(A_IN, 32'h0000_FFFF);
    rd(A_IN, d0); chk("R8 write ignored", 64'(d0), 64'hA5A5);
  endtask

  task automatic t_open_drain;
    wr(A_MODE, 32'h5555_5555);
    wr(A_TYPE, 32'h0000_FFFF);
    wr(A_OUT, 32'h0000_00FF);
    chk("R9 od out", 64'(pad_out), 64'h00FF);
    chk("R9 od oe", 64'(pad_oe), 64'hFF00);
    chk("R9 pad_od", 64'(pad_od), 64'hFFFF);
    wr(A_TYPE, 32'h0);
  endtask

  task automatic t_alt;
    af_out = 16'h1234; af_oe = 16'h00FF;
    wr(A_OUT, 32'h0000_FFFF);
    wr(A_MODE, 32'hAAAA_AAAA);
    chk("R10 alt out", 64'(pad_out), 64'h1234);
    chk("R10 alt oe", 64'(pad_oe), 64'h00FF);
    wr(A_MODE, 32'hAAAA_AAA5);
    chk("R10 mixed oe", 64'(pad_oe), 64'h00FF);
    chk("R10 mixed out", 64'(pad_out), 64'h1237);
  endtask

  task automatic t_idle;
    wr(A_OUT, 32'h0000_FFFF);
    wr(A_MODE, 32'hFFFF_0000);
    chk("R11 no drive", 64'(pad_oe), 64'h0);
    chk("R11 analog", 64'(pad_analog), 64'hFF00);
    wr(A_PULL, 32'h0000_0036);
    chk("R11 pull up", 64'(pad_pu), 64'h0002);
    chk("R11 pull down", 64'(pad_pd), 64'h0001);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(A_MODE, 32'h0000_0055);
    wr(6'h28, 32'hFFFF_FFFF);
    wr(6'h01, 32'hFFFF_FFFF);
    rd(A_MODE, d); chk("R12 stray write", 64'(d), 64'h0000_0055);
    rd(A_OUT, d);  chk("R12 odr kept", 64'(d), 64'h0000_FFFF);
    rd(6'h28, d);  chk("R12 unmapped read", 64'(d), 64'h0);
    rd(6'h01, d);  chk("R12 misaligned read", 64'(d), 64'h0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    bus_addr = A_MODE; bus_rd = 1'b1;
    chk("R13 before edge", 64'(bus_rdata), 64'h0);
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R13 after edge", 64'(bus_rdata), 64'h55);
    @(negedge clk);
    chk("R13 idle zero", 64'(bus_rdata), 64'h0);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_be = '0;
    bus_rd = 1'b0; pin_in = '0; af_out = '0; af_oe = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_config;
    t_strobes;
    t_odr;
    t_setclr;
    t_clr;
    t_input;
    t_open_drain;
    t_alt;
    t_idle;
    t_unmapped;
    t_latency;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule